// File: doc/BRIEF.md
# Charge-Transfer Burst Acquisition Sequencer

This block controls burst-mode charge-transfer measurement of four capacitive keys that share one sampling capacitor. For each key it opens a burst by briefly closing a discharge switch across the capacitor. It then repeats a fixed pulse cycle that steers a charge switch, a transfer switch and the selected X drive line. It counts the completed cycles until an external comparator reports that the capacitor voltage has reached the reference. The count is the measured burst length. A larger count means less charge moved per pulse.

A start tick from a period timer launches one burst. Successive bursts walk through the keys in a fixed rotation. Each result (12-bit length, key index, timeout flag) leaves through a valid/ready output port. A result stays on the port with its data unchanged until the consumer takes it. The sequencer starts no new burst while an untaken result holds the port. A start tick that arrives while a burst is running, or while the port is full, is dropped. The one exception is a tick in the same cycle as the result is taken, which is accepted. The switches and the capacitor lie outside the block.

Top module: `ct_burst_acq`

## Requirements
- R1: While reset is asserted the X drive enable is low (lines tri-stated). From the first clock after release it is high. After reset all three switches are open, all X lines are low and no result is valid.
- R2: A burst begins with the discharge switch closed for exactly PH_CLKS clocks. It then opens, and one phase of PH_CLKS clocks with every switch open follows before the first charge.
- R3: Each pulse cycle is six phases of PH_CLKS clocks each. The phases run: charge closes; the selected X line rises with charge still closed; charge opens; transfer closes; the X line falls with transfer still closed; transfer opens. The X line is high only while either charge or transfer is closed, or during the gap between them.
- R4: The charge and transfer switches are never closed together. At least one clock with both open separates a charge opening from the next transfer closing.
- R5: Only the X line of the key being measured pulses during its burst. Bit i of x_drv belongs to key i, and every other line stays low.
- R6: The comparator is sampled in the last clock of each cycle. When it is high the burst ends, and res_len equals the number of completed cycles with res_timeout = 0.
- R7: If 4095 cycles complete without the comparator being high, the burst stops with res_len = 4095 and res_timeout = 1.
- R8: res_key is the key of the burst. Bursts measure keys in the order 0, 1, 2, 3, 0, ...
- R9: While res_valid is high and res_ready is low, res_valid stays high and res_len, res_key and res_timeout do not change. A result leaves when res_valid and res_ready are both high at a clock edge.
- R10: A start tick is taken only when no burst runs and the output port is empty or being emptied in that same cycle. Any other tick has no effect.
- R11: Between bursts all switches are open and all X lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_tick | input | 1 | One-clock request to measure the next key |
| cmp_hit | input | 1 | Comparator: capacitor has reached the reference |
| sw_dump | output | 1 | Closes the capacitor discharge switch |
| sw_chg | output | 1 | Closes the charge switch |
| sw_xfr | output | 1 | Closes the transfer switch |
| x_drv | output | 4 | X drive line levels, bit i for key i |
| x_oe | output | 1 | X line drive enable, low only while in reset |
| res_valid | output | 1 | Result present on the port |
| res_ready | input | 1 | Consumer takes the result |
| res_len | output | 12 | Burst length in pulse cycles |
| res_key | output | 2 | Key index of the result |
| res_timeout | output | 1 | Burst stopped at the cycle limit |

## Verification
Two events can fall in the same cycle: the consumer taking a waiting result and a new start tick. The bench holds res_ready low until a result is waiting and first sends a lone tick, which must be dropped. It then raises res_ready and pulses start_tick on the same clock edge. The scoreboard must see the stalled result unchanged, and then a complete new burst for the next key. The discharge-phase count confirms that the new burst really began.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RST,
    PH_RGAP,
    PH_CHG,
    PH_XUP,
    PH_GAP,
    PH_XFR,
    PH_XDN,
    PH_END
  } phase_e;
endpackage

// File: rtl/ct_phase_seq.sv
module ct_phase_seq
  import ct_pkg::*;
#(
  parameter int KEYS    = 4,
  parameter int PH_CLKS = 2,
  localparam int KW = $clog2(KEYS),
  localparam int TW = $clog2(PH_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hit,
  input  logic          cnt_last,
  output phase_e        phase,
  output logic [KW-1:0] key,
  output logic          cyc_done,
  output logic          fin,
  output logic          busy
);
  logic [TW-1:0] tmr;
  logic          ph_end;
  phase_e        nxt;

  assign ph_end   = (tmr == TW'(PH_CLKS - 1));
  assign busy     = (phase != PH_IDLE);
  assign cyc_done = (phase == PH_END) && ph_end;
  assign fin      = cyc_done && (hit || cnt_last);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: nxt = PH_IDLE;
      PH_RST:  nxt = PH_RGAP;
      PH_RGAP: nxt = PH_CHG;
      PH_CHG:  nxt = PH_XUP;
      PH_XUP:  nxt = PH_GAP;
      PH_GAP:  nxt = PH_XFR;
      PH_XFR:  nxt = PH_XDN;
      PH_XDN:  nxt = PH_END;
      PH_END:  nxt = (hit || cnt_last) ? PH_IDLE : PH_CHG;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tmr   <= '0;
      key   <= '0;
    end else if (!busy) begin
      tmr <= '0;
      if (start) phase <= PH_RST;
    end else if (ph_end) begin
      tmr   <= '0;
      phase <= nxt;
      if (fin) key <= (key == KW'(KEYS - 1)) ? '0 : key + KW'(1);
    end else begin
      tmr <= tmr + TW'(1);
    end
  end
endmodule

// File: rtl/ct_burst_count.sv
module ct_burst_count #(
  parameter int CW = 12,
  localparam int MAXC = (1 << CW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = (cnt == CW'(MAXC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/ct_xdrive.sv
module ct_xdrive
  import ct_pkg::*;
#(
  parameter int KEYS = 4,
  localparam int KW = $clog2(KEYS)
) (
  input  phase_e          phase,
  input  logic [KW-1:0]   key,
  output logic [KEYS-1:0] x_drv
);
  logic x_hi;
  assign x_hi = (phase == PH_XUP) || (phase == PH_GAP) || (phase == PH_XFR);

  for (genvar i = 0; i < KEYS; i++) begin : g_line
    assign x_drv[i] = x_hi && (key == KW'(i));
  end
endmodule

// File: rtl/ct_result_slot.sv
module ct_result_slot #(
  parameter int CW = 12,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len_in,
  input  logic [KW-1:0] key_in,
  input  logic          to_in,
  input  logic          ready,
  output logic          valid,
  output logic [CW-1:0] len,
  output logic [KW-1:0] key,
  output logic          to
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      len   <= '0;
      key   <= '0;
      to    <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      len   <= len_in;
      key   <= key_in;
      to    <= to_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ct_burst_acq.sv
module ct_burst_acq
  import ct_pkg::*;
#(
  parameter int KEYS    = 4,
  parameter int CW      = 12,
  parameter int PH_CLKS = 2,
  localparam int KW = $clog2(KEYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_tick,
  input  logic            cmp_hit,
  output logic            sw_dump,
  output logic            sw_chg,
  output logic            sw_xfr,
  output logic [KEYS-1:0] x_drv,
  output logic            x_oe,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [CW-1:0]   res_len,
  output logic [KW-1:0]   res_key,
  output logic            res_timeout
);
  phase_e        phase;
  logic [KW-1:0] key;
  logic          cyc_done, fin, busy, start, cnt_last;
  logic [CW-1:0] cnt;

  assign start = start_tick && !busy && (!res_valid || res_ready);

  ct_phase_seq #(.KEYS(KEYS), .PH_CLKS(PH_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(cmp_hit),
    .cnt_last(cnt_last), .phase(phase), .key(key),
    .cyc_done(cyc_done), .fin(fin), .busy(busy)
  );

  ct_burst_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(cyc_done),
    .cnt(cnt), .last(cnt_last)
  );

  ct_xdrive #(.KEYS(KEYS)) u_xd (
    .phase(phase), .key(key), .x_drv(x_drv)
  );

  ct_result_slot #(.CW(CW), .KW(KW)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(fin),
    .len_in(cnt + CW'(1)), .key_in(key), .to_in(!cmp_hit),
    .ready(res_ready), .valid(res_valid), .len(res_len),
    .key(res_key), .to(res_timeout)
  );

  assign sw_dump = (phase == PH_RST);
  assign sw_chg  = (phase == PH_CHG) || (phase == PH_XUP);
  assign sw_xfr  = (phase == PH_XFR) || (phase == PH_XDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_oe <= 1'b0;
    else        x_oe <= 1'b1;
  end
endmodule

// File: rtl/ct_burst_acq_chk.sv
module ct_burst_acq_chk #(
  parameter int KEYS = 4,
  parameter int CW   = 12,
  parameter int KW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_dump,
  input logic            sw_chg,
  input logic            sw_xfr,
  input logic [KEYS-1:0] x_drv,
  input logic            res_valid,
  input logic            res_ready,
  input logic [CW-1:0]   res_len,
  input logic [KW-1:0]   res_key,
  input logic            res_timeout
);
  p_sw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_chg && sw_xfr));

  p_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_chg) |-> !sw_xfr);

  p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_drv));

  p_dump_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_dump |-> (!sw_chg && !sw_xfr && x_drv == '0));

  p_x_at_xfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_xfr) |-> (x_drv != '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_len) && $stable(res_key) && $stable(res_timeout)));

  p_len_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len != '0));
endmodule

bind ct_burst_acq ct_burst_acq_chk #(.KEYS(KEYS), .CW(CW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_dump(sw_dump), .sw_chg(sw_chg),
  .sw_xfr(sw_xfr), .x_drv(x_drv), .res_valid(res_valid),
  .res_ready(res_ready), .res_len(res_len), .res_key(res_key),
  .res_timeout(res_timeout)
);

// File: tb/ct_burst_acq_tb_top.sv
module ct_burst_acq_tb_top;
  localparam int PH  = 2;
  localparam int TH  = 1000;
  localparam int LIM = 4095;

  typedef struct packed {
    logic [1:0]  k;
    logic [11:0] n;
    logic        to;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_tick = 1'b0;
  logic cmp_hit;
  logic sw_dump, sw_chg, sw_xfr, x_oe;
  logic [3:0] x_drv;
  logic res_valid, res_ready = 1'b1, res_timeout;
  logic [11:0] res_len;
  logic [1:0] res_key;

  always #2.5 clk = ~clk;

  ct_burst_acq dut_i (
    .clk(clk), .rst_n(rst_n), .start_tick(start_tick), .cmp_hit(cmp_hit),
    .sw_dump(sw_dump), .sw_chg(sw_chg), .sw_xfr(sw_xfr), .x_drv(x_drv),
    .x_oe(x_oe), .res_valid(res_valid), .res_ready(res_ready),
    .res_len(res_len), .res_key(res_key), .res_timeout(res_timeout)
  );

  int n_chk = 0, n_bad = 0;
  int pushed = 0, got = 0;
  int rst_cnt = 0, seq_err = 0, ovl_err = 0, xsel_err = 0;
  int step_of [4];
  int cur_key = 0, k_exp = 0;
  item_t expq[$];

  // capacitor model: discharged by the dump switch, one charge step per transfer
  int v = 0;
  logic xfr_q = 1'b0;
  always @(posedge clk) begin
    if (sw_dump) v <= 0;
    else if (sw_xfr && !xfr_q) begin
      for (int i = 0; i < 4; i++) if (x_drv[i]) v <= v + step_of[i];
    end
    xfr_q <= sw_xfr;
  end
  assign cmp_hit = (v >= TH);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // switch-order observer, sampled away from the edge
  logic p_chg = 0, p_xfr = 0, p_dump = 0;
  logic [3:0] p_x = 0;
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (sw_dump) rst_cnt++;
      if (sw_chg && sw_xfr) ovl_err++;
      if (sw_xfr && !p_xfr && p_chg) ovl_err++;
      if (sw_chg && !p_chg && p_dump) seq_err++;
      if ((x_drv & ~p_x) != 0 && !sw_chg) seq_err++;
      if (!sw_chg && p_chg && x_drv == 0) seq_err++;
      if (sw_xfr && !p_xfr && x_drv == 0) seq_err++;
      if (x_drv == 0 && p_x != 0 && !sw_xfr) seq_err++;
      if ((x_drv & ~(4'b1 << cur_key)) != 0) xsel_err++;
    end
    p_chg = sw_chg; p_xfr = sw_xfr; p_dump = sw_dump; p_x = x_drv;
  end

  // scoreboard monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && res_valid && res_ready) begin
      if (expq.size() == 0) begin
        check(0, "R10 unexpected result", 1, 0);
      end else begin
        item_t e;
        e = expq.pop_front();
        check(res_key == e.k, "R8 key", res_key, e.k);
        check(res_len == e.n, e.to ? "R7 length" : "R6 length", res_len, e.n);
        check(res_timeout == e.to, "R7 timeout flag", res_timeout, e.to);
      end
      got++;
    end
  end

  task automatic push_exp(input int s);
    item_t e;
    int n;
    n = (s == 0) ? LIM + 1 : (TH + s - 1) / s;
    e.k = k_exp[1:0];
    e.to = (n > LIM);
    e.n = (n > LIM) ? 12'(LIM) : 12'(n);
    step_of[k_exp] = s;
    expq.push_back(e);
    pushed++;
    cur_key = k_exp;
    k_exp = (k_exp + 1) % 4;
  endtask

  task automatic wait_done();
    while (got < pushed) @(negedge clk);
  endtask

  task automatic post_checks();
    check(rst_cnt == PH, "R2 discharge length", rst_cnt, PH);
    check(seq_err == 0, "R3 switch order", seq_err, 0);
    check(ovl_err == 0, "R4 charge/transfer overlap", ovl_err, 0);
    check(xsel_err == 0, "R5 foreign X line", xsel_err, 0);
    @(negedge clk); #1;
    check({sw_dump, sw_chg, sw_xfr, x_drv} == 0, "R11 idle outputs",
          {sw_dump, sw_chg, sw_xfr, x_drv}, 0);
  endtask

  task automatic burst(input int s, input bit busy_tick);
    @(negedge clk);
    push_exp(s);
    rst_cnt = 0;
    start_tick = 1'b1;
    @(negedge clk);
    start_tick = 1'b0;
    if (busy_tick) begin
      repeat (20) @(negedge clk);
      start_tick = 1'b1;     // R10: ignored, burst running
      @(negedge clk);
      start_tick = 1'b0;
    end
    wait_done();
    post_checks();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    check(0, "watchdog", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    item_t held;
    foreach (step_of[i]) step_of[i] = 1;
    repeat (3) @(negedge clk);
    #1;
    check(x_oe == 0, "R1 tri-state in reset", x_oe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(x_oe == 1, "R1 drive enable", x_oe, 1);
    check({sw_dump, sw_chg, sw_xfr, x_drv, res_valid} == 0, "R1 reset outputs",
          {sw_dump, sw_chg, sw_xfr, x_drv, res_valid}, 0);

    // scan A: assorted lengths, stray tick during the first burst
    burst(10, 1);
    burst(7, 0);
    burst(300, 0);
    burst(1000, 0);
    // stray tick must not have launched anything
    rst_cnt = 0;
    repeat (200) @(negedge clk);
    check(rst_cnt == 0 && !res_valid, "R10 tick while busy", rst_cnt, 0);

    // scan B: timeout and short bursts
    burst(0, 0);
    burst(3, 0);
    burst(999, 0);
    burst(500, 0);

    // back-pressure and same-cycle accept/tick
    @(negedge clk);
    res_ready = 1'b0;
    push_exp(50);
    rst_cnt = 0;
    start_tick = 1'b1;
    @(negedge clk);
    start_tick = 1'b0;
    while (!res_valid) @(negedge clk);
    #1;
    held = {res_key, res_len, res_timeout};
    repeat (8) @(negedge clk);
    #1;
    check({res_key, res_len, res_timeout} == held && res_valid, "R9 stalled hold",
          {res_key, res_len, res_timeout}, held);
    @(negedge clk);
    rst_cnt = 0;
    start_tick = 1'b1;       // R10: ignored, port full
    @(negedge clk);
    start_tick = 1'b0;
    repeat (10) @(negedge clk);
    check(rst_cnt == 0, "R10 tick while port full", rst_cnt, 0);
    @(negedge clk);
    res_ready = 1'b1;
    start_tick = 1'b1;       // same cycle as acceptance
    @(negedge clk);
    start_tick = 1'b0;
    push_exp(25);
    wait_done();
    post_checks();
    check(expq.size() == 0, "R10 queue drained", expq.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule